// File: doc/BRIEF.md
# PPS-Disciplined Interval Timestamp Counter

This block keeps a free-running count of 10 ns ticks. Its clock is a 100 MHz clock that is assumed to be phase-locked to an external 10 MHz reference. It serves two timing needs of a host. The first is measuring the time between successive host reads. The second is time-stamping each rising edge of an asynchronous pulse-per-second input. The host talks to it through a small synchronous read port, which consists of an offset, a read strobe and a registered data word.

Three offsets carry meaning:
- Offset 0x0 returns the count as it stands, with no side effects.
- Offset 0x4 returns the count as an interval and restarts the count at that instant. The returned word also carries a wrapping tally of seconds pulses.
- Offset 0x8 returns the count that was captured at the most recent seconds edge.

The interval restart is built from two counters that alternate roles. The counter going out is frozen at its final value, and the counter coming in starts at 1 in the same cycle, so no tick is dropped.

Top module: `pps_stamp_counter`

## Requirements
- R1: While out of reset, the active count rises by exactly 1 on every clock edge and wraps to 0 after 2^CNT_W-1. The default is CNT_W=24, which spans about 167 ms at 100 MHz. In the first cycle after reset the count is 0.
- R2: A strobe at offset 0x0 returns the active count as it stood at the strobe edge. It changes no state, so a later read keeps counting from the same base.
- R3: A strobe at offset 0x4 returns the active count at the strobe edge in bits CNT_W-1:0. That value is the number of clock edges since the previous 0x4 strobe, or since reset minus one. In the same edge the other counter becomes active with the value 1.
- R4: The seconds input passes through two synchronising flops and then a rising-edge detector. When the input is first sampled high at edge k, the edge is acted on at edge k+2, and the capture register then takes the active count of that edge.
- R5: A PPS_W-bit seconds tally (8 bits by default) rises by 1 at each detected rising edge and wraps modulo 2^PPS_W. It is returned in the top PPS_W bits of the 0x4 word, which are bits 31:24 by default.
- R6: A strobe at offset 0x8 returns the capture register, zero-extended, with no side effects.
- R7: If a seconds edge and a 0x4 strobe fall in the same cycle, the capture register takes the count from before the switch. The tally returned by that strobe already includes that edge.
- R8: Read data appears one cycle after the strobe. Read data is zero in any cycle that follows no strobe. A strobe at any offset other than 0x0, 0x4 or 0x8 returns zero and has no side effect.
- R9: A synchronous active-high reset clears both counters, the capture register, the tally and the read data, and makes counter 0 active.
- R10: Only low-to-high transitions are counted. An input held high, or a falling transition, neither advances the tally nor reloads the capture register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz counting clock, locked to the 10 MHz reference |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W (4) | Byte offset of the read |
| rd_data | output | CNT_W+PPS_W (32) | Registered read word, valid the cycle after rd_en |

## Verification
The hardest case to reach from the ports is a seconds edge that is acted on in the same cycle as an interval strobe. This is because the edge shows up two cycles after the input rises. The bench therefore raises the input, waits exactly two edges, and only then issues the 0x4 strobe. It then checks both the returned tally and the capture register against the count from before the switch. Both wraps are reached by building the bench with a 10-bit count and a 6-bit tally, so that seventy pulses and a long idle stretch cover them.

// File: rtl/pps_stamp_pkg.sv
`timescale 1ns/1ps
package pps_stamp_pkg;

  localparam int unsigned OFS_LIVE  = 32'h0;
  localparam int unsigned OFS_SWAP  = 32'h4;
  localparam int unsigned OFS_LATCH = 32'h8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_SWAP  = 2'd2,
    SEL_LATCH = 2'd3
  } rd_sel_e;

  function automatic rd_sel_e decode_offset(input int unsigned ofs);
    case (ofs)
      OFS_LIVE:  return SEL_LIVE;
      OFS_SWAP:  return SEL_SWAP;
      OFS_LATCH: return SEL_LATCH;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pps_sync_edge.sv
`timescale 1ns/1ps
module pps_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  output logic pps_rise
);
  // sh[STAGES-1:0] is the synchroniser, sh[STAGES] the previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pps_in};
  end

  assign pps_rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pingpong_interval.sv
`timescale 1ns/1ps
module pingpong_interval #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap,
  output logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] held_cnt,
  output logic             act_sel
);
  logic [1:0][CNT_W-1:0] cnt_q;
  logic                  sel_q;

  always_ff @(posedge clk) begin
    if (rst)       sel_q <= 1'b0;
    else if (swap) sel_q <= ~sel_q;
  end

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) begin
        c <= '0;
      end else if (sel_q == 1'(g)) begin
        if (!swap) c <= c + CNT_W'(1);
      end else if (swap) begin
        c <= CNT_W'(1);
      end
    end
    assign cnt_q[g] = c;
  end

  assign live_cnt = cnt_q[sel_q];
  assign held_cnt = cnt_q[~sel_q];
  assign act_sel  = sel_q;
endmodule

// File: rtl/pps_capture.sv
`timescale 1ns/1ps
module pps_capture #(
  parameter int CNT_W = 24,
  parameter int PPS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_rise,
  input  logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] pps_latch,
  output logic [PPS_W-1:0] pps_cnt,
  output logic [PPS_W-1:0] pps_cnt_nxt
);
  assign pps_cnt_nxt = pps_cnt + PPS_W'(pps_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_latch <= '0;
      pps_cnt   <= '0;
    end else begin
      pps_cnt <= pps_cnt_nxt;
      if (pps_rise) pps_latch <= live_cnt;
    end
  end
endmodule

// File: rtl/pps_stamp_counter.sv
`timescale 1ns/1ps
module pps_stamp_counter
  import pps_stamp_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PPS_W  = 8,
  parameter int ADDR_W = 4,
  localparam int DATA_W = CNT_W + PPS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  rd_sel_e          rd_sel;
  logic             swap_evt;
  logic             pps_rise;
  logic             act_sel;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] held_cnt;
  logic [CNT_W-1:0] pps_latch;
  logic [PPS_W-1:0] pps_cnt;
  logic [PPS_W-1:0] pps_cnt_nxt;
  logic [DATA_W-1:0] rd_word;

  assign rd_sel   = rd_en ? decode_offset(32'(rd_addr)) : SEL_NONE;
  assign swap_evt = (rd_sel == SEL_SWAP);

  pps_sync_edge #(.STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .pps_in(pps_in), .pps_rise(pps_rise)
  );

  pingpong_interval #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .swap(swap_evt),
    .live_cnt(live_cnt), .held_cnt(held_cnt), .act_sel(act_sel)
  );

  pps_capture #(.CNT_W(CNT_W), .PPS_W(PPS_W)) cap_i (
    .clk(clk), .rst(rst), .pps_rise(pps_rise), .live_cnt(live_cnt),
    .pps_latch(pps_latch), .pps_cnt(pps_cnt), .pps_cnt_nxt(pps_cnt_nxt)
  );

  always_comb begin
    case (rd_sel)
      SEL_LIVE:  rd_word = DATA_W'(live_cnt);
      SEL_SWAP:  rd_word = {pps_cnt_nxt, live_cnt};
      SEL_LATCH: rd_word = DATA_W'(pps_latch);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/pps_stamp_counter_chk.sv
`timescale 1ns/1ps
module pps_stamp_counter_chk
  import pps_stamp_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PPS_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [CNT_W+PPS_W-1:0]  rd_data,
  input logic                    swap_evt,
  input logic                    pps_rise,
  input logic [CNT_W-1:0]        live_cnt,
  input logic [CNT_W-1:0]        held_cnt,
  input logic [CNT_W-1:0]        pps_latch,
  input logic [PPS_W-1:0]        pps_cnt
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !swap_evt |=> live_cnt == CNT_W'($past(live_cnt) + CNT_W'(1)));
  // R3
  swap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    swap_evt |=> live_cnt == CNT_W'(1) && held_cnt == $past(live_cnt));
  // R4
  pps_capture_chk: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> pps_latch == $past(live_cnt));
  // R5
  pps_tally_chk: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> pps_cnt == PPS_W'($past(pps_cnt) + PPS_W'(1)));
  // R10
  pps_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pps_rise |=> $stable(pps_cnt) && $stable(pps_latch));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && decode_offset(32'(rd_addr)) == SEL_NONE) |=> rd_data == '0);
  // R2
  live_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && decode_offset(32'(rd_addr)) == SEL_LIVE)
      |=> rd_data == (CNT_W+PPS_W)'($past(live_cnt)));
endmodule

bind pps_stamp_counter pps_stamp_counter_chk #(
  .CNT_W(CNT_W), .PPS_W(PPS_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .swap_evt(swap_evt), .pps_rise(pps_rise), .live_cnt(live_cnt),
  .held_cnt(held_cnt), .pps_latch(pps_latch), .pps_cnt(pps_cnt)
);

// File: tb/pps_stamp_counter_tb_top.sv
`timescale 1ns/1ps
module pps_stamp_counter_tb_top;
  localparam int CW = 10;
  localparam int PW = 6;
  localparam int DW = CW + PW;
  localparam int CMASK = (1 << CW) - 1;
  localparam int PMOD  = 1 << PW;

  logic clk = 1'b0;
  logic rst, pps_in, rd_en;
  logic [3:0] rd_addr;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int ecnt = 0;
  int base, pps_n, exp_latch;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  pps_stamp_counter #(.CNT_W(CW), .PPS_W(PW), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .pps_in(pps_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int cnt_at(input int k);
    return (k - base) & CMASK;
  endfunction

  // called at a negedge; returns at the negedge after the strobe edge
  task automatic do_read(input logic [3:0] a, output logic [DW-1:0] d, output int k);
    rd_en = 1'b1; rd_addr = a; k = ecnt + 1;
    @(negedge clk);
    d = rd_data; rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic pps_rise(input int high, input int low);
    int kp;
    pps_in = 1'b1; kp = ecnt + 1;
    exp_latch = (kp + 2 - base) & CMASK;
    pps_n = (pps_n + 1) % PMOD;
    repeat (high) @(negedge clk);
    pps_in = 1'b0;
    repeat (low) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; base = 1; pps_n = 0; exp_latch = 0;
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] d;
    int k, k2, kp;
    rst = 1'b1; pps_in = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    chk("R9", "rd_data in reset", rd_data, 0);
    rst = 1'b0; base = 1; pps_n = 0; exp_latch = 0;

    // R1 count starts at 0 right after reset, R2 live reads
    do_read(4'h0, d, k);  chk("R1", "first live count", d, 0);
    repeat (5) @(negedge clk);
    do_read(4'h0, d, k);  chk("R2", "live count", d, cnt_at(k));
    do_read(4'h0, d, k2); chk("R2", "live count back-to-back", d, cnt_at(k2));
    @(negedge clk);
    chk("R8", "idle rd_data", rd_data, 0);
    do_read(4'h8, d, k);  chk("R6", "latch after reset", d, 0);

    // R3 interval reads with every gap from 0 to 11
    for (int g = 0; g < 12; g++) begin
      repeat (g) @(negedge clk);
      do_read(4'h4, d, k);
      chk("R3", "interval word", d, (pps_n << CW) | cnt_at(k));
      base = k;
    end
    do_read(4'h0, d, k);  chk("R3", "new counter starts at 1", d, 1);

    // R8 unmapped offsets: zero and no side effect
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        do_read(4'(a), d, k); chk("R8", "unmapped offset", d, 0);
      end
    end
    do_read(4'h0, d, k);  chk("R8", "no restart from unmapped", d, cnt_at(k));
    do_read(4'h8, d, k);  chk("R8", "latch untouched by unmapped", d, 0);

    // R4 / R6 capture, R5 tally, R10 held high counts once
    pps_rise(20, 4);
    do_read(4'h8, d, k);  chk("R4", "pps latch value", d, exp_latch);
    do_read(4'h8, d, k);  chk("R6", "latch read no side effect", d, exp_latch);
    do_read(4'h4, d, k);  chk("R10", "held high counts once", d >> CW, pps_n);
    base = k;
    repeat (6) @(negedge clk);
    do_read(4'h8, d, k);  chk("R10", "falling edge keeps latch", d, exp_latch);

    // R5 tally wrap
    for (int p = 0; p < 70; p++) pps_rise(2, 3);
    do_read(4'h4, d, k);  chk("R5", "tally after wrap", d, (pps_n << CW) | cnt_at(k));
    base = k;
    do_read(4'h8, d, k);  chk("R4", "latch after pulse train", d, exp_latch);

    // R1 counter wrap
    repeat (1100) @(negedge clk);
    do_read(4'h0, d, k);  chk("R1", "live count after wrap", d, cnt_at(k));
    do_read(4'h4, d, k);  chk("R1", "interval after wrap", d, (pps_n << CW) | cnt_at(k));
    base = k;

    // R7 seconds edge coincident with interval strobe
    repeat (7) @(negedge clk);
    pps_in = 1'b1; kp = ecnt + 1;
    @(negedge clk); @(negedge clk);
    do_read(4'h4, d, k);
    chk("R7", "strobe lands on edge cycle", k, kp + 2);
    chk("R7", "tally includes edge", d >> CW, (pps_n + 1) % PMOD);
    chk("R7", "interval count", d & CMASK, cnt_at(k));
    exp_latch = cnt_at(k); pps_n = (pps_n + 1) % PMOD; base = k;
    pps_in = 1'b0;
    do_read(4'h8, d, k);  chk("R7", "latch holds pre-switch count", d, exp_latch);
    do_read(4'h0, d, k);  chk("R7", "count after coincident switch", d, cnt_at(k));

    // R9 reset in the middle of activity
    pps_in = 1'b1;
    @(negedge clk);
    do_reset();
    pps_in = 1'b0;
    do_read(4'h8, d, k);  chk("R9", "latch cleared", d, 0);
    do_read(4'h4, d, k);  chk("R9", "tally and count cleared", d, k - 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule